// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Converter

This block turns a phase word into a signed sine sample for a direct digital synthesis chain. It sits between a phase accumulator and a DAC. Only one quadrant of the wave is stored: a table of 2^N magnitudes runs from sin(0) up to the last point below sin(π/2). A separate register supplies the crest value at the two phase points where the wave peaks. The two most significant phase bits name the quadrant. The converter reflects the table address in the second and fourth quadrants and flips the sign of the result in the lower half-cycle. As a result, every quadrant boundary falls on a distinct sample and no stored value appears twice in a row.

The table contents are computed at elaboration. The table entry at address a is round(2^(W-1) · sin(π·a / 2^(N+1))), clamped to 2^(W-1)−1, where W is the output width. The full-scale setting is N = 16 (an 18-bit phase, a 65536-entry table and a 14-bit output). The parameter defaults use N = 10 (a 12-bit phase) to keep the elaborated table small. Everything else is unchanged between the two settings.

Top module: `sine_quarter_lut`

## Requirements
- R1: While rst_n is low, and on the first sample after rst_n is released, `sample` is 0.
- R2: The sample for a phase appears one rising clock edge after that phase is presented. Before that edge the output still shows the previous result.
- R3: With phase bits [N+1:N] = 00 and offset k = phase[N-1:0], `sample` equals table entry k.
- R4: With quadrant bits 01 and a nonzero offset k, `sample` equals table entry 2^N − k. For example, offset 1 reads entry 2^N−1 and offset 2^N−1 reads entry 1.
- R5: With quadrant bits 01 and offset 0, `sample` is the crest value +(2^(W-1)−1), which is +8191 for W = 14. It is taken from the crest register, not from the table.
- R6: With quadrant bits 10 and offset k, `sample` equals the negated table entry k.
- R7: With quadrant bits 11 and a nonzero offset k, `sample` equals the negated table entry 2^N − k.
- R8: With quadrant bits 11 and offset 0, `sample` is −(2^(W-1)−1), which is −8191 for W = 14.
- R9: Phase 0 and phase 2^(N+1), the half-cycle point, both give exactly 0.
- R10: `sample` never takes the value −2^(W-1). The output range is symmetric about zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | N+2 | Quadrant in the top two bits, offset below |
| sample | output | W | Two's-complement sine sample |

## Verification
A wrong reflection of the address shows as a sample read from the wrong side of the quadrant. The error is largest near the quadrant edges, and it appears on the first clock after such a phase is presented. A stale sign or crest strobe, left out of step with the table read, gives a sample of the wrong polarity, or the crest value at the wrong point, one cycle after a quadrant crossing. For these reasons the bench sweeps every phase code back to back and probes the four boundary points on both sides.

// File: rtl/sinelut_pkg.sv
package sinelut_pkg;

  // Control-to-datapath strobes, aligned with the registered table read.
  typedef struct packed {
    logic negate;   // lower half-cycle: flip the sign
    logic usePeak;  // crest point: take the crest register
  } lutStrobes_t;

endpackage

// File: rtl/sinelut_ctrl.sv
module sinelut_ctrl
  import sinelut_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFF_W+1:0]   phase,
  output logic [OFF_W-1:0]   romAddr,
  output lutStrobes_t        strobes
);

  localparam logic [OFF_W:0] FULL_SPAN = (OFF_W+1)'(1) << OFF_W;

  logic [OFF_W-1:0] offset;
  logic             mirrorQuad;
  logic             lowerHalf;
  logic [OFF_W:0]   reflected;
  lutStrobes_t      nextStrobes;

  assign offset     = phase[OFF_W-1:0];
  assign mirrorQuad = phase[OFF_W];
  assign lowerHalf  = phase[OFF_W+1];

  // Reflect the offset in the falling quadrants: entry = 2^N - k.
  always_comb begin
    reflected = FULL_SPAN - {1'b0, offset};
    romAddr   = mirrorQuad ? reflected[OFF_W-1:0] : offset;
  end

  always_comb begin
    nextStrobes.negate  = lowerHalf;
    nextStrobes.usePeak = mirrorQuad && (offset == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobes <= '0;
    else        strobes <= nextStrobes;
  end

  // R6
  negate_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (strobes.negate == $past(phase[OFF_W+1])));

  // R5
  peak_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && phase[OFF_W] && (phase[OFF_W-1:0] == '0)) |=> strobes.usePeak);

endmodule

// File: rtl/sinelut_data.sv
module sinelut_data
  import sinelut_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int OUT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  romAddr,
  input  lutStrobes_t       strobes,
  output logic [OUT_W-1:0]  sample
);

  localparam int  DEPTH      = 1 << OFF_W;
  localparam int  MAG_W      = OUT_W - 1;
  localparam int  SCALE      = 1 << MAG_W;
  localparam int  PEAK       = SCALE - 1;
  localparam real PI_VAL     = 3.14159265358979323846;
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};
  localparam logic [OUT_W-1:0] PEAK_POS = OUT_W'(PEAK);
  localparam logic [OUT_W-1:0] PEAK_NEG = OUT_W'(-PEAK);

  function automatic logic [MAG_W-1:0] quarterSample(input int idx);
    real ang;
    real amp;
    int  val;
    ang = PI_VAL * real'(idx) / (2.0 * real'(DEPTH));
    amp = real'(SCALE) * $sin(ang);
    val = $rtoi(amp + 0.5);
    if (val > PEAK) val = PEAK;
    return MAG_W'(val);
  endfunction

  logic [MAG_W-1:0] quarterRom [DEPTH];
  logic [MAG_W-1:0] romQ;
  logic [MAG_W-1:0] crestReg;
  logic [OUT_W-1:0] magnitude;

  initial begin
    for (int i = 0; i < DEPTH; i++) quarterRom[i] = quarterSample(i);
  end

  assign crestReg = MAG_W'(PEAK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) romQ <= '0;
    else        romQ <= quarterRom[romAddr];
  end

  always_comb begin
    magnitude = strobes.usePeak ? {1'b0, crestReg} : {1'b0, romQ};
    sample    = strobes.negate ? (~magnitude + OUT_W'(1)) : magnitude;
  end

  // R10
  no_most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample != MOST_NEG);

  // R8
  crest_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.usePeak |-> (sample == PEAK_POS || sample == PEAK_NEG));

  // R7
  lower_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.negate |-> (sample[OUT_W-1] || sample == '0));

  // R3
  upper_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.negate |-> !sample[OUT_W-1]);

endmodule

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut
  import sinelut_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int OUT_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFF_W+1:0]   phase,
  output logic [OUT_W-1:0]   sample
);

  logic [OFF_W-1:0] romAddr;
  lutStrobes_t      strobes;

  sinelut_ctrl #(.OFF_W(OFF_W)) ctrlUnit (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .romAddr (romAddr),
    .strobes (strobes)
  );

  sinelut_data #(.OFF_W(OFF_W), .OUT_W(OUT_W)) dataUnit (
    .clk     (clk),
    .rst_n   (rst_n),
    .romAddr (romAddr),
    .strobes (strobes),
    .sample  (sample)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (sample == '0));

endmodule

// File: tb/sine_quarter_lut_test.sv
module sine_quarter_lut_test;

  localparam int OFF_W = 10;
  localparam int OUT_W = 14;
  localparam int PH_W  = OFF_W + 2;
  localparam int DEPTH = 1 << OFF_W;
  localparam int SCALE = 1 << (OUT_W - 1);
  localparam int PEAK  = SCALE - 1;

  localparam int NVEC = 16;
  localparam int VEC_PHASE [NVEC] = '{
    0, 1, 5, 511, 1023, 1024, 1025, 1500,
    2047, 2048, 2049, 2600, 3071, 3072, 3073, 4095
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PH_W-1:0]   phase = '0;
  logic [OUT_W-1:0]  sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sine_quarter_lut #(.OFF_W(OFF_W), .OUT_W(OUT_W)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .sample (sample)
  );

  always #10 clk = ~clk;

  function automatic int tableVal(input int a);
    real r;
    int  v;
    r = real'(SCALE) * $sin(3.14159265358979323846 * real'(a) / (2.0 * real'(DEPTH)));
    v = $rtoi(r + 0.5);
    if (v > PEAK) v = PEAK;
    return v;
  endfunction

  function automatic int expectVal(input int ph);
    int q;
    int k;
    q = (ph >> OFF_W) & 3;
    k = ph & (DEPTH - 1);
    case (q)
      0:       return tableVal(k);
      1:       return (k == 0) ? PEAK : tableVal(DEPTH - k);
      2:       return -tableVal(k);
      default: return (k == 0) ? -PEAK : -tableVal(DEPTH - k);
    endcase
  endfunction

  function automatic string reqTag(input int ph);
    int q;
    int k;
    q = (ph >> OFF_W) & 3;
    k = ph & (DEPTH - 1);
    if (k == 0 && (q == 0 || q == 2)) return "R9";
    case (q)
      0:       return "R3";
      1:       return (k == 0) ? "R5" : "R4";
      2:       return "R6";
      default: return (k == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Present a phase at a falling edge, then read the result one falling edge later.
  task automatic applyPhase(input int ph);
    @(negedge clk);
    phase = PH_W'(ph);
    @(negedge clk);
    check(reqTag(ph), int'($signed(sample)), expectVal(ph));
    // R10
    check("R10", int'(sample == {1'b1, {(OUT_W-1){1'b0}}}), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    phase = PH_W'(1024);
    #35;
    // R1: output held at zero during reset
    check("R1", int'($signed(sample)), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'($signed(sample)), 0);

    // Table walk over the quadrant boundaries
    for (int i = 0; i < NVEC; i++) applyPhase(VEC_PHASE[i]);

    // R9: both zero crossings exactly zero
    applyPhase(0);
    check("R9", int'($signed(sample)), 0);
    applyPhase(2 * DEPTH);
    check("R9", int'($signed(sample)), 0);

    // R5 / R8: crests
    applyPhase(DEPTH);
    check("R5", int'($signed(sample)), PEAK);
    applyPhase(3 * DEPTH);
    check("R8", int'($signed(sample)), -PEAK);

    // R4 / R7: mirror end points read entries 2^N-1 and 1
    applyPhase(DEPTH + 1);
    check("R4", int'($signed(sample)), tableVal(DEPTH - 1));
    applyPhase(2 * DEPTH - 1);
    check("R4", int'($signed(sample)), tableVal(1));
    applyPhase(4 * DEPTH - 1);
    check("R7", int'($signed(sample)), -tableVal(1));

    // R2: one-edge latency, old value held until the edge
    @(negedge clk);
    phase = PH_W'(DEPTH);
    #1;
    check("R2", int'($signed(sample)), -tableVal(1));
    @(posedge clk);
    #1;
    check("R2", int'($signed(sample)), PEAK);

    // Exhaustive back-to-back sweep of every phase code
    @(negedge clk);
    phase = '0;
    for (int p = 1; p <= 4 * DEPTH; p++) begin
      @(negedge clk);
      check(reqTag(p - 1), int'($signed(sample)), expectVal(p - 1));
      phase = PH_W'(p % (4 * DEPTH));
    end

    // R1: mid-run reset clears the output
    applyPhase(DEPTH);
    rst_n = 1'b0;
    #3;
    check("R1", int'($signed(sample)), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'($signed(sample)), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule